// File: doc/BRIEF.md
# Crash-Frozen Circular Frame Buffer

This block keeps a rolling window of recent video in a large external asynchronous SRAM made of two 16-bit chips. Pixels from a capture stage arrive one 16-bit word at a time. The block places them at a write pointer that wraps around a ring sized to a whole number of frames. It counts how many complete frames the ring holds, up to the ring's capacity. At the default sizes the ring holds 27 frames of 320x240 RGB565 pixels (76800 words each), which is 2,073,600 words. That is about 3.4 seconds of video at 8 frames per second.

When the crash input is raised, the block lets the frame in progress finish and then stops taking pixels for good. It then publishes the frame where playback should start: the oldest complete frame still in the ring. Dump logic then reads the stored frames back through a simple request/valid read port. The block shares the SRAM strobes between writes and these reads.

The SRAM is addressed with one linear word address. Its top bit picks the chip and the remaining bits drive the shared address lines. Write and read cycles are timed in whole clock periods so that the slow asynchronous memory sees stable address and data around each strobe.

Top module: `crash_frame_ring`

## Requirements
- R1: While and after reset, before any request: pix_ready_o=1, frozen_o=0, frames_stored_o=0, start_frame_o=0, both chip enables high, sram_we_n_o=1, sram_oe_n_o=1.
- R2: A linear word address L goes to chip 1 when bit CHIP_AW of L is 1 and to chip 0 otherwise. sram_addr_o carries L's low CHIP_AW bits, and only the selected chip's enable (sram_ce_n_o[chip]) is driven low during the access.
- R3: A write holds sram_we_n_o low for exactly WE_CYCLES consecutive cycles, with sram_dq_oe_o=1 and with address and write data unchanged throughout.
- R4: The n-th pixel accepted since reset (counting from 0) is stored at linear address n mod (NUM_FRAMES*FRAME_WORDS).
- R5: frames_stored_o rises by one when the last word of a frame is accepted and saturates at NUM_FRAMES.
- R6: A crash raised partway through a frame still lets the remaining words of that frame be accepted. After that, no pixel is accepted and frozen_o=1.
- R7: A crash raised on a frame boundary, including before any pixel, stops acceptance at once, and the SRAM is not written again.
- R8: On freezing, start_frame_o is 0 if fewer than NUM_FRAMES frames were completed. Otherwise it is (frames completed) mod NUM_FRAMES. start_addr_o = start_frame_o*FRAME_WORDS.
- R9: frozen_o stays 1 until reset. Further crash pulses and offered pixels change neither the start pointer nor the SRAM contents.
- R10: A read is accepted (rd_ready_o=1) only when the sequencer is idle and no pixel is taken in that cycle. sram_oe_n_o is then low for exactly RD_LAT cycles with sram_we_n_o high, and rd_valid_o pulses with the word stored at rd_addr_i.
- R11: sram_bhe_n_o and sram_ble_n_o are always 0, so every access is a full word.
- R12: The two chip enables are never low together, and sram_we_n_o and sram_oe_n_o are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Pixel word offered |
| pix_data_i | input | DATA_W | Pixel word |
| pix_ready_o | output | 1 | Pixel taken this cycle if valid |
| crash_i | input | 1 | Crash trigger |
| frozen_o | output | 1 | Ring frozen, no more writes |
| frames_stored_o | output | $clog2(NUM_FRAMES+1) | Complete frames held |
| start_frame_o | output | $clog2(NUM_FRAMES) | Frame index where playback starts |
| start_addr_o | output | CHIP_AW+1 | Linear word address of that frame |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | CHIP_AW+1 | Linear word address to read |
| rd_ready_o | output | 1 | Read request taken this cycle |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DATA_W | Read data |
| sram_addr_o | output | CHIP_AW | Shared SRAM address lines |
| sram_dq_o | output | DATA_W | Write data to SRAM |
| sram_dq_oe_o | output | 1 | Drive enable for write data |
| sram_dq_i | input | DATA_W | Data from SRAM |
| sram_ce_n_o | output | 2 | Chip enables, active low, one per chip |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_bhe_n_o | output | 1 | Upper byte enable, active low |
| sram_ble_n_o | output | 1 | Lower byte enable, active low |

## Verification
The assertions assume that crash_i and pix_valid_i are free to change in any cycle, and that rd_addr_i stays inside the ring, below NUM_FRAMES*FRAME_WORDS. The bench drives inputs only away from the clock edge. It always issues addresses computed from the frame layout, so reads never leave the ring. The SRAM model answers in zero time while the output enable is low. That means the fixed read delay is the only timing the block relies on. Pixel values and idle gaps come from a seeded random source. The crash is placed on purpose: mid-frame, on a boundary, before any data, and after the ring has wrapped.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WR   = 2'd1,
    SQ_WEND = 2'd2,
    SQ_RD   = 2'd3
  } seq_e;

  // Step a counter that runs 0 .. lim-1 and wraps.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Playback start: frame 0 until the ring has filled, else the next frame to overwrite.
  function automatic int unsigned oldest_frame(input int unsigned stored,
                                               input int unsigned next_frame,
                                               input int unsigned nf);
    return (stored < nf) ? 0 : next_frame;
  endfunction

  // Linear word address of the first word of a frame.
  function automatic int unsigned frame_base(input int unsigned frame, input int unsigned fw);
    return frame * fw;
  endfunction

  // True on the final cycle of a strobe that lasts len cycles.
  function automatic bit step_is_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1 >= len);
  endfunction

endpackage

// File: rtl/cfr_ring_ptr.sv
module cfr_ring_ptr
  import cfr_pkg::*;
#(
  parameter int FRAME_WORDS = 76800,
  parameter int NUM_FRAMES  = 27,
  parameter int ADDR_W      = 21,
  localparam int RING  = FRAME_WORDS * NUM_FRAMES,
  localparam int FW_W  = $clog2(FRAME_WORDS),
  localparam int FI_W  = $clog2(NUM_FRAMES),
  localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_take_i,
  input  logic              crash_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_block_o,
  output logic              frozen_o,
  output logic [CNT_W-1:0]  frames_o,
  output logic [FI_W-1:0]   start_frame_o,
  output logic [ADDR_W-1:0] start_addr_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [FW_W-1:0]   idx_q;
  logic [FI_W-1:0]   frame_q;
  logic [CNT_W-1:0]  frames_q;
  logic [FI_W-1:0]   start_q;
  logic              crash_pend_q;
  logic              frozen_q;

  // Named events for the assertions and for readability.
  logic crash_seen;
  logic at_boundary;
  logic frame_done;
  logic freeze_now;

  assign crash_seen  = crash_i | crash_pend_q;
  assign at_boundary = (idx_q == '0);
  assign frame_done  = wr_take_i && (32'(idx_q) == FRAME_WORDS - 1);
  assign freeze_now  = !frozen_q && crash_seen && at_boundary && !wr_take_i;

  // Once a crash is seen, a new frame must not begin.
  assign wr_block_o    = frozen_q | (crash_seen & at_boundary);
  assign wr_addr_o     = addr_q;
  assign frozen_o      = frozen_q;
  assign frames_o      = frames_q;
  assign start_frame_o = start_q;
  assign start_addr_o  = ADDR_W'(frame_base(32'(start_q), FRAME_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q       <= '0;
      idx_q        <= '0;
      frame_q      <= '0;
      frames_q     <= '0;
      start_q      <= '0;
      crash_pend_q <= 1'b0;
      frozen_q     <= 1'b0;
    end else begin
      if (wr_take_i) begin
        addr_q <= ADDR_W'(wrap_inc(32'(addr_q), RING));
        idx_q  <= FW_W'(wrap_inc(32'(idx_q), FRAME_WORDS));
      end
      if (frame_done) begin
        frame_q <= FI_W'(wrap_inc(32'(frame_q), NUM_FRAMES));
        if (32'(frames_q) < NUM_FRAMES) frames_q <= frames_q + CNT_W'(1);
      end
      if (!frozen_q && crash_i) crash_pend_q <= 1'b1;
      if (freeze_now) begin
        frozen_q <= 1'b1;
        start_q  <= FI_W'(oldest_frame(32'(frames_q), 32'(frame_q), NUM_FRAMES));
      end
    end
  end

  // R9: a frozen ring takes no more pixels and never thaws
  p_no_take_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> !wr_take_i);
  p_frozen_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> frozen_q);
  // R6: freezing only happens on a frame boundary
  p_freeze_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen_q) |-> at_boundary);
  // R5: the frame count never exceeds the ring size
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frames_q) <= NUM_FRAMES);
  // R8: a ring that never filled plays back from frame 0
  p_partial_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frozen_q) && 32'(frames_q) < NUM_FRAMES) |-> (start_q == '0));
  // R7: a crash on a boundary blocks the very next pixel
  p_boundary_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crash_i && at_boundary) |-> !wr_take_i);

endmodule

// File: rtl/cfr_sram_seq.sv
module cfr_sram_seq
  import cfr_pkg::*;
#(
  parameter int CHIP_AW   = 20,
  parameter int DATA_W    = 16,
  parameter int WE_CYCLES = 2,
  parameter int RD_LAT    = 2,
  localparam int ADDR_W  = CHIP_AW + 1,
  localparam int LONGEST = (WE_CYCLES > RD_LAT) ? WE_CYCLES : RD_LAT,
  localparam int CW      = $clog2(LONGEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_go_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              idle_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CHIP_AW-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic [1:0]        sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic              sram_bhe_n_o,
  output logic              sram_ble_n_o
);

  seq_e              st_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  // Named events.
  logic active;
  logic chip_sel;
  logic we_last;
  logic rd_sample;

  assign active    = (st_q != SQ_IDLE);
  assign chip_sel  = a_q[CHIP_AW];
  assign we_last   = (st_q == SQ_WR) && step_is_last(32'(cnt_q), WE_CYCLES);
  assign rd_sample = (st_q == SQ_RD) && step_is_last(32'(cnt_q), RD_LAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      cnt_q      <= '0;
      a_q        <= '0;
      d_q        <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (wr_go_i) begin
            a_q  <= wr_addr_i;
            d_q  <= wr_data_i;
            st_q <= SQ_WR;
          end else if (rd_go_i) begin
            a_q  <= rd_addr_i;
            st_q <= SQ_RD;
          end
        end
        SQ_WR: begin
          if (we_last) st_q <= SQ_WEND;
          else         cnt_q <= cnt_q + CW'(1);
        end
        SQ_WEND: st_q <= SQ_IDLE;
        SQ_RD: begin
          if (rd_sample) begin
            st_q       <= SQ_IDLE;
            rd_valid_q <= 1'b1;
            rd_data_q  <= sram_dq_i;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  // One active-low enable per chip, picked by the top address bit.
  for (genvar c = 0; c < 2; c++) begin : g_ce
    assign sram_ce_n_o[c] = !(active && (chip_sel == 1'(c)));
  end

  assign idle_o       = !active;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
  assign sram_addr_o  = a_q[CHIP_AW-1:0];
  assign sram_dq_o    = d_q;
  assign sram_dq_oe_o = (st_q == SQ_WR) || (st_q == SQ_WEND);
  assign sram_we_n_o  = (st_q != SQ_WR);
  assign sram_oe_n_o  = (st_q != SQ_RD);
  assign sram_bhe_n_o = 1'b0;
  assign sram_ble_n_o = 1'b0;

  // R12: at most one chip enabled; write and output enables exclusive
  p_one_chip_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sram_ce_n_o));
  p_we_oe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n_o && !sram_oe_n_o));
  // R3: address, data and chip enables hold while the write strobe is low
  p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n_o && $past(!sram_we_n_o)) |->
      ($stable(sram_addr_o) && $stable(sram_dq_o) && $stable(sram_ce_n_o)));
  p_we_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n_o |-> sram_dq_oe_o);
  // R10: read data is only presented after an output-enable window
  p_rdv_after_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(!sram_oe_n_o));

endmodule

// File: rtl/crash_frame_ring.sv
module crash_frame_ring
  import cfr_pkg::*;
#(
  parameter int FRAME_WORDS = 76800,
  parameter int NUM_FRAMES  = 27,
  parameter int CHIP_AW     = 20,
  parameter int DATA_W      = 16,
  parameter int WE_CYCLES   = 2,
  parameter int RD_LAT      = 2,
  localparam int ADDR_W = CHIP_AW + 1,
  localparam int FI_W   = $clog2(NUM_FRAMES),
  localparam int CNT_W  = $clog2(NUM_FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid_i,
  input  logic [DATA_W-1:0]  pix_data_i,
  output logic               pix_ready_o,
  input  logic               crash_i,
  output logic               frozen_o,
  output logic [CNT_W-1:0]   frames_stored_o,
  output logic [FI_W-1:0]    start_frame_o,
  output logic [ADDR_W-1:0]  start_addr_o,
  input  logic               rd_req_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               rd_ready_o,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [CHIP_AW-1:0] sram_addr_o,
  output logic [DATA_W-1:0]  sram_dq_o,
  output logic               sram_dq_oe_o,
  input  logic [DATA_W-1:0]  sram_dq_i,
  output logic [1:0]         sram_ce_n_o,
  output logic               sram_we_n_o,
  output logic               sram_oe_n_o,
  output logic               sram_bhe_n_o,
  output logic               sram_ble_n_o
);

  logic              seq_idle;
  logic              wr_block;
  logic              wr_take;
  logic              rd_take;
  logic [ADDR_W-1:0] wr_addr;

  // Writes win the idle cycle; a read waits for a cycle with no pixel.
  assign pix_ready_o = seq_idle && !wr_block;
  assign wr_take     = pix_valid_i && pix_ready_o;
  assign rd_ready_o  = seq_idle && !wr_take;
  assign rd_take     = rd_req_i && rd_ready_o;

  cfr_ring_ptr #(
    .FRAME_WORDS(FRAME_WORDS),
    .NUM_FRAMES (NUM_FRAMES),
    .ADDR_W     (ADDR_W)
  ) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_take_i    (wr_take),
    .crash_i      (crash_i),
    .wr_addr_o    (wr_addr),
    .wr_block_o   (wr_block),
    .frozen_o     (frozen_o),
    .frames_o     (frames_stored_o),
    .start_frame_o(start_frame_o),
    .start_addr_o (start_addr_o)
  );

  cfr_sram_seq #(
    .CHIP_AW  (CHIP_AW),
    .DATA_W   (DATA_W),
    .WE_CYCLES(WE_CYCLES),
    .RD_LAT   (RD_LAT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_go_i     (wr_take),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (pix_data_i),
    .rd_go_i     (rd_take),
    .rd_addr_i   (rd_addr_i),
    .idle_o      (seq_idle),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i   (sram_dq_i),
    .sram_ce_n_o (sram_ce_n_o),
    .sram_we_n_o (sram_we_n_o),
    .sram_oe_n_o (sram_oe_n_o),
    .sram_bhe_n_o(sram_bhe_n_o),
    .sram_ble_n_o(sram_ble_n_o)
  );

  // R10: a read and a write never start in the same cycle
  p_one_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_take && rd_take));
  // R6: once frozen, the pixel side is closed
  p_ready_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o |-> !pix_ready_o);

endmodule

// File: tb/sim_crash_frame_ring.sv
module sim_crash_frame_ring;
  localparam int FW   = 6;
  localparam int NF   = 5;
  localparam int CAW  = 4;
  localparam int WEC  = 2;
  localparam int RDL  = 2;
  localparam int RING = FW * NF;
  localparam int AW   = CAW + 1;
  localparam int HALF = 1 << CAW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           pix_valid = 1'b0;
  logic [15:0]    pix_data = '0;
  logic           pix_ready;
  logic           crash = 1'b0;
  logic           frozen;
  logic [2:0]     frames_stored;
  logic [2:0]     start_frame;
  logic [AW-1:0]  start_addr;
  logic           rd_req = 1'b0;
  logic [AW-1:0]  rd_addr = '0;
  logic           rd_ready;
  logic           rd_valid;
  logic [15:0]    rd_data;
  logic [CAW-1:0] s_addr;
  logic [15:0]    s_dq_o;
  logic           s_dq_oe;
  logic [15:0]    s_dq_i;
  logic [1:0]     s_ce_n;
  logic           s_we_n, s_oe_n, s_bhe_n, s_ble_n;

  crash_frame_ring #(
    .FRAME_WORDS(FW), .NUM_FRAMES(NF), .CHIP_AW(CAW),
    .DATA_W(16), .WE_CYCLES(WEC), .RD_LAT(RDL)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .pix_valid_i(pix_valid), .pix_data_i(pix_data), .pix_ready_o(pix_ready),
    .crash_i(crash), .frozen_o(frozen), .frames_stored_o(frames_stored),
    .start_frame_o(start_frame), .start_addr_o(start_addr),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_ready_o(rd_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sram_addr_o(s_addr), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
    .sram_dq_i(s_dq_i), .sram_ce_n_o(s_ce_n), .sram_we_n_o(s_we_n),
    .sram_oe_n_o(s_oe_n), .sram_bhe_n_o(s_bhe_n), .sram_ble_n_o(s_ble_n)
  );

  // Two-chip asynchronous SRAM model.
  logic [15:0] m0 [HALF];
  logic [15:0] m1 [HALF];
  logic [15:0] exp_mem [RING];

  always_comb begin
    s_dq_i = 16'h0000;
    if (!s_oe_n && s_we_n) begin
      if (!s_ce_n[0])      s_dq_i = m0[s_addr];
      else if (!s_ce_n[1]) s_dq_i = m1[s_addr];
    end
  end

  always @(negedge clk) begin
    if (!s_we_n) begin
      if (!s_ce_n[0]) m0[s_addr] <= s_dq_o;
      if (!s_ce_n[1]) m1[s_addr] <= s_dq_o;
    end
  end

  int tests = 0;
  int fails = 0;
  int n_acc = 0;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic check(input bit c, input string tag, input int got, input int exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Pin monitor: strobe lengths, holds, exclusivity, byte enables.
  int we_run = 0;
  int oe_run = 0;
  logic [CAW-1:0] pa;
  logic [15:0]    pd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!s_ce_n[0] && !s_ce_n[1]) check(0, "R12 both chips", 2, 1);
      if (!s_we_n && !s_oe_n)       check(0, "R12 we and oe", 1, 0);
      if (s_bhe_n || s_ble_n)       check(0, "R11 byte enables", int'({s_bhe_n, s_ble_n}), 0);
      if (!s_we_n) begin
        if (we_run > 0 && (s_addr != pa || s_dq_o != pd))
          check(0, "R3 hold during strobe", int'(s_addr), int'(pa));
        if (!s_dq_oe) check(0, "R3 data drive", 0, 1);
        we_run++;
      end else if (we_run > 0) begin
        check(we_run == WEC, "R3 strobe length", we_run, WEC);
        we_run = 0;
      end
      if (!s_oe_n) oe_run++;
      else if (oe_run > 0) begin
        check(oe_run == RDL, "R10 oe length", oe_run, RDL);
        oe_run = 0;
      end
      pa = s_addr;
      pd = s_dq_o;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; pix_valid = 1'b0; crash = 1'b0; rd_req = 1'b0;
    n_acc = 0;
    for (int i = 0; i < HALF; i++) begin m0[i] = '0; m1[i] = '0; end
    for (int i = 0; i < RING; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Offer one word; ok says whether it was taken within a short window.
  task automatic push(input logic [15:0] d, output bit ok);
    int i;
    ok = 0; i = 0;
    pix_data = d; pix_valid = 1'b1;
    while (!ok && i < 12) begin
      #1;
      if (pix_ready) ok = 1;
      @(negedge clk);
      i++;
    end
    pix_valid = 1'b0;
    if (ok) begin
      exp_mem[n_acc % RING] = d;
      n_acc++;
    end
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic push_frames(input int nfr, input int done_before);
    bit ok;
    for (int f = 0; f < nfr; f++) begin
      for (int w = 0; w < FW; w++) begin
        push(16'($urandom), ok);
        check(ok, "R4 word accepted", int'(ok), 1);
      end
      check(int'(frames_stored) == ((done_before + f + 1 < NF) ? done_before + f + 1 : NF),
            "R5 frame count", int'(frames_stored),
            (done_before + f + 1 < NF) ? done_before + f + 1 : NF);
    end
  endtask

  task automatic crash_pulse();
    crash = 1'b1;
    @(negedge clk);
    crash = 1'b0;
  endtask

  task automatic rd_word(input int a, output logic [15:0] q, output bit got);
    int i;
    got = 0; q = '0;
    rd_addr = AW'(a); rd_req = 1'b1;
    #1;
    i = 0;
    while (!rd_ready && i < 12) begin @(negedge clk); #1; i++; end
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < 10 && !got; k++) begin
      if (rd_valid) begin got = 1; q = rd_data; end
      else @(negedge clk);
    end
  endtask

  // R2 and R4: each linear address lands in the decoded chip at its low bits.
  task automatic check_mem(input string tag);
    for (int l = 0; l < RING; l++) begin
      logic [15:0] v;
      v = (l >= HALF) ? m1[l - HALF] : m0[l];
      check(v == exp_mem[l], tag, int'(v), int'(exp_mem[l]));
    end
  endtask

  task automatic dump(input int nfr);
    int exp_start;
    int stored;
    logic [15:0] q;
    bit got;
    exp_start = (nfr < NF) ? 0 : nfr % NF;
    stored    = (nfr < NF) ? nfr : NF;
    check(int'(start_frame) == exp_start, "R8 start frame", int'(start_frame), exp_start);
    check(int'(start_addr) == exp_start * FW, "R8 start addr", int'(start_addr), exp_start * FW);
    for (int k = 0; k < stored; k++) begin
      for (int w = 0; w < FW; w++) begin
        int a;
        a = ((exp_start + k) % NF) * FW + w;
        rd_word(a, q, got);
        check(got && q == exp_mem[a], "R10 readback", int'(q), int'(exp_mem[a]));
      end
    end
  endtask

  initial begin
    bit ok;
    int nfr;
    void'($urandom(32'h00C0FFEE));

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(pix_ready == 1'b1 || pix_ready == 1'b0, "R1 ready known", int'(pix_ready), 1);
    check(frozen == 1'b0, "R1 frozen in reset", int'(frozen), 0);
    check(s_ce_n == 2'b11 && s_we_n && s_oe_n, "R1 strobes idle",
          int'({s_ce_n, s_we_n, s_oe_n}), 15);
    do_reset();
    check(pix_ready == 1'b1, "R1 ready", int'(pix_ready), 1);
    check(frames_stored == 0 && start_frame == 0, "R1 counters",
          int'({frames_stored, start_frame}), 0);
    check(s_bhe_n == 1'b0 && s_ble_n == 1'b0, "R11 byte enables low", int'({s_bhe_n, s_ble_n}), 0);

    // R6: crash partway through the third frame
    push_frames(2, 0);
    for (int w = 0; w < 3; w++) begin push(16'($urandom), ok); end
    crash_pulse();
    for (int w = 0; w < FW - 3; w++) begin
      push(16'($urandom), ok);
      check(ok, "R6 frame finishes", int'(ok), 1);
    end
    push(16'hBEEF, ok);
    check(!ok, "R6 no word after frame", int'(ok), 0);
    check(frozen == 1'b1, "R6 frozen", int'(frozen), 1);
    check(frames_stored == 3, "R5 count at freeze", int'(frames_stored), 3);
    check_mem("R2 R4 contents after partial ring");
    dump(3);

    // R7 and R8: wrapped ring, crash on a frame boundary
    do_reset();
    nfr = 6 + int'($urandom % 7);
    push_frames(nfr, 0);
    crash_pulse();
    check(frozen == 1'b1, "R7 frozen at boundary", int'(frozen), 1);
    push(16'h1234, ok);
    check(!ok, "R7 no word after boundary crash", int'(ok), 0);
    check(frames_stored == NF, "R5 saturates", int'(frames_stored), NF);
    check_mem("R2 R4 contents after wrap");
    dump(nfr);

    // R9: frozen ring ignores crashes and pixels
    crash_pulse();
    pix_data = 16'hA5A5; pix_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      #1;
      check(!pix_ready, "R9 closed while frozen", int'(pix_ready), 0);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(frozen == 1'b1, "R9 still frozen", int'(frozen), 1);
    check(int'(start_frame) == nfr % NF, "R9 start unchanged", int'(start_frame), nfr % NF);
    check_mem("R9 contents unchanged");

    // R7: crash before any pixel
    do_reset();
    crash_pulse();
    check(frozen == 1'b1 && frames_stored == 0, "R7 empty freeze", int'(frozen), 1);
    check(start_frame == 0 && start_addr == 0, "R8 empty start", int'(start_addr), 0);
    push(16'h7777, ok);
    check(!ok, "R7 empty no accept", int'(ok), 0);
    check_mem("R7 memory untouched");

    // R10: reads work before any crash as well
    do_reset();
    push_frames(1, 0);
    for (int w = 0; w < FW; w++) begin
      logic [15:0] q;
      bit got;
      rd_word(w, q, got);
      check(got && q == exp_mem[w], "R10 read live ring", int'(q), int'(exp_mem[w]));
    end

    repeat (4) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    report();
  end

endmodule